// File: doc/BRIEF.md
# Peak-Hold Display Register Controller

This block sits between a measurement result (a voltage conversion or a frequency count) and the register that feeds the digit display. Each measurement arrives as a magnitude, a sign and an over-range flag, qualified by a one-cycle end-of-conversion strobe. On each strobe the controller decides whether the display register takes the new reading. The decision depends on three things: a freeze input, a peak-hold input, and a comparison of the new reading's absolute value with the one already stored.

A three-state machine carries the decision. The states are `S_TRACK`, `S_PEAK` and `S_FREEZE`, and the state is re-evaluated from the mode inputs on every clock:
- Any state goes to `S_FREEZE` while freeze is high.
- Otherwise any state goes to `S_PEAK` while peak-hold is high.
- Otherwise any state goes to `S_TRACK`.

In `S_TRACK` every strobe loads. In `S_PEAK` only a strictly larger reading loads. In `S_FREEZE` no strobe loads.

Alongside the register, combinational status logic produces the rest of the display status:
- the overload ("OL") indication and the over-range annunciator;
- the logic-probe low-level and high-level annunciators;
- the buzzer enable;
- the decimal-point enables, which are blanked in logic-probe mode while the voltage function is selected.

Top module: `phd_ctrl`

## Requirements
- R1: After reset the stored magnitude is 0, and the stored sign and stored over-range flag are both 0.
- R2: In `S_TRACK`, a strobe loads the reading's magnitude, sign and over-range flag into the display register. Without a strobe the register keeps its value whatever the reading inputs do.
- R3: In `S_FREEZE`, strobes are ignored and the display register is unchanged. Freeze takes priority over peak-hold.
- R4: In `S_PEAK`, with both the stored and new readings in range, a strobe loads only when the new magnitude is strictly greater than the stored one. The sign plays no part in the comparison. Otherwise the stored value is held for any number of strobes.
- R5: In the peak comparison, an over-range reading is greater than any in-range stored reading. An over-range reading never replaces a stored over-range reading, and an in-range reading never replaces it either.
- R6: Once peak-hold is deasserted and the state has returned to `S_TRACK`, the next strobe loads regardless of magnitude.
- R7: Freeze and peak-hold are registered into the state at each clock edge. A strobe is therefore governed by the state from the previous cycle, so a strobe in the same cycle that peak-hold first rises still loads as in `S_TRACK`.
- R8: `show_ol` is high when the stored over-range flag is 1 or when logic-probe mode is on. `ovr_ann` equals the stored over-range flag.
- R9: `lo_ann` and `hi_ann` follow `probe_lo` and `probe_hi` in logic-probe mode and are 0 outside it.
- R10: `buz_en` is the OR of `buz_req` and `lo_ann`.
- R11: `dp_out` is all zeros when logic-probe mode is on with the voltage function selected (`func_cnt` = 0). In every other case it equals `dp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eoc | input | 1 | End-of-conversion strobe, one cycle |
| rd_mag | input | MAG_W | Reading magnitude |
| rd_neg | input | 1 | Reading sign, 1 = negative |
| rd_ovr | input | 1 | Reading is over range |
| freeze | input | 1 | Hold the display, ignore strobes |
| peak_en | input | 1 | Peak-hold mode |
| probe_mode | input | 1 | Logic-probe mode |
| func_cnt | input | 1 | 1 = counter function, 0 = voltage function |
| probe_lo | input | 1 | Logic-low detect input |
| probe_hi | input | 1 | Logic-high detect input |
| buz_req | input | 1 | External buzzer request |
| dp_in | input | DP_W | Decimal-point enables from upstream |
| disp_mag | output | MAG_W | Stored display magnitude |
| disp_neg | output | 1 | Stored display sign |
| disp_ovr | output | 1 | Stored over-range flag |
| show_ol | output | 1 | Show the overload legend |
| ovr_ann | output | 1 | Over-range annunciator |
| lo_ann | output | 1 | Low-level probe annunciator |
| hi_ann | output | 1 | High-level probe annunciator |
| buz_en | output | 1 | Buzzer enable |
| dp_out | output | DP_W | Decimal-point enables to the display |

## Verification
The assertions assume that the strobe and the mode inputs are synchronous to the clock and hold stable values across each sampling edge. They also assume that the mode inputs may change in any cycle, including one with a strobe.

The bench meets this by driving every input on the falling edge only. It holds each mode setting for at least one full cycle before issuing a strobe, except in the one deliberate test of mode and strobe arriving in the same cycle. The peak comparison is swept over every pair of stored and new magnitudes in a 4-bit configuration. The status logic is swept over all 32 combinations of its control inputs.

// File: rtl/phd_pkg.sv
package phd_pkg;
    typedef enum logic [1:0] {
        S_TRACK  = 2'd0,
        S_PEAK   = 2'd1,
        S_FREEZE = 2'd2
    } phd_state_e;
endpackage

// File: rtl/phd_cmp.sv
module phd_cmp #(
    parameter int MAG_W = 12
) (
    input  logic [MAG_W-1:0] new_mag,
    input  logic             new_ovr,
    input  logic [MAG_W-1:0] old_mag,
    input  logic             old_ovr,
    output logic             bigger
);
    logic mag_gt;

    assign mag_gt = (new_mag > old_mag);

    always_comb begin
        unique case ({new_ovr, old_ovr})
            2'b10:   bigger = 1'b1;
            2'b00:   bigger = mag_gt;
            default: bigger = 1'b0;
        endcase
    end

    always_comb begin
        if (old_ovr) begin
            a_ovr_top_r5: assert (!bigger);
        end
    end
endmodule

// File: rtl/phd_fsm.sv
module phd_fsm
    import phd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  logic       peak_en,
    input  logic       eoc,
    input  logic       bigger,
    output logic       load,
    output phd_state_e state
);
    phd_state_e state_nx;

    always_comb begin
        if (freeze)       state_nx = S_FREEZE;
        else if (peak_en) state_nx = S_PEAK;
        else              state_nx = S_TRACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_TRACK;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_TRACK:  load = eoc;
            S_PEAK:   load = eoc && bigger;
            S_FREEZE: load = 1'b0;
            default:  load = 1'b0;
        endcase
    end

    p_freeze_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && peak_en) |=> (state == S_FREEZE));
    p_state_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && peak_en) |=> (state == S_PEAK));
endmodule

// File: rtl/phd_status.sv
module phd_status #(
    parameter int DP_W = 3
) (
    input  logic            probe_mode,
    input  logic            func_cnt,
    input  logic            probe_lo,
    input  logic            probe_hi,
    input  logic            buz_req,
    input  logic            stored_ovr,
    input  logic [DP_W-1:0] dp_in,
    output logic            show_ol,
    output logic            ovr_ann,
    output logic            lo_ann,
    output logic            hi_ann,
    output logic            buz_en,
    output logic [DP_W-1:0] dp_out
);
    logic dp_blank;

    assign dp_blank = probe_mode && !func_cnt;

    always_comb begin
        show_ol = stored_ovr || probe_mode;
        ovr_ann = stored_ovr;
        lo_ann  = probe_mode && probe_lo;
        hi_ann  = probe_mode && probe_hi;
        buz_en  = buz_req || lo_ann;
    end

    for (genvar i = 0; i < DP_W; i++) begin : g_dp
        assign dp_out[i] = dp_in[i] && !dp_blank;
    end
endmodule

// File: rtl/phd_ctrl.sv
module phd_ctrl
    import phd_pkg::*;
#(
    parameter int MAG_W = 12,
    parameter int DP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc,
    input  logic [MAG_W-1:0] rd_mag,
    input  logic             rd_neg,
    input  logic             rd_ovr,
    input  logic             freeze,
    input  logic             peak_en,
    input  logic             probe_mode,
    input  logic             func_cnt,
    input  logic             probe_lo,
    input  logic             probe_hi,
    input  logic             buz_req,
    input  logic [DP_W-1:0]  dp_in,
    output logic [MAG_W-1:0] disp_mag,
    output logic             disp_neg,
    output logic             disp_ovr,
    output logic             show_ol,
    output logic             ovr_ann,
    output logic             lo_ann,
    output logic             hi_ann,
    output logic             buz_en,
    output logic [DP_W-1:0]  dp_out
);
    logic       bigger;
    logic       load;
    phd_state_e state;

    phd_cmp #(.MAG_W(MAG_W)) u_cmp (
        .new_mag (rd_mag),
        .new_ovr (rd_ovr),
        .old_mag (disp_mag),
        .old_ovr (disp_ovr),
        .bigger  (bigger)
    );

    phd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .freeze  (freeze),
        .peak_en (peak_en),
        .eoc     (eoc),
        .bigger  (bigger),
        .load    (load),
        .state   (state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_mag <= '0;
            disp_neg <= 1'b0;
            disp_ovr <= 1'b0;
        end else if (load) begin
            disp_mag <= rd_mag;
            disp_neg <= rd_neg;
            disp_ovr <= rd_ovr;
        end
    end

    phd_status #(.DP_W(DP_W)) u_status (
        .probe_mode (probe_mode),
        .func_cnt   (func_cnt),
        .probe_lo   (probe_lo),
        .probe_hi   (probe_hi),
        .buz_req    (buz_req),
        .stored_ovr (disp_ovr),
        .dp_in      (dp_in),
        .show_ol    (show_ol),
        .ovr_ann    (ovr_ann),
        .lo_ann     (lo_ann),
        .hi_ann     (hi_ann),
        .buz_en     (buz_en),
        .dp_out     (dp_out)
    );

    p_no_eoc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc |=> ($stable(disp_mag) && $stable(disp_neg) && $stable(disp_ovr)));
    p_track_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRACK && eoc) |=> (disp_mag == $past(rd_mag) && disp_ovr == $past(rd_ovr)));
    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FREEZE) |=> ($stable(disp_mag) && $stable(disp_neg) && $stable(disp_ovr)));
    p_peak_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEAK) |=> ($past(disp_ovr) ? (disp_ovr && $stable(disp_mag))
                                               : (disp_ovr || disp_mag >= $past(disp_mag))));
    p_ol_shown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ovr |-> (show_ol && ovr_ann));
    p_buzz_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ann |-> buz_en);
endmodule

// File: tb/tb_phd_ctrl.sv
module tb_phd_ctrl;
    localparam int MAG_W = 4;
    localparam int DP_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eoc = 1'b0;
    logic [MAG_W-1:0] rd_mag = '0;
    logic rd_neg = 1'b0, rd_ovr = 1'b0, freeze = 1'b0, peak_en = 1'b0;
    logic probe_mode = 1'b0, func_cnt = 1'b0, probe_lo = 1'b0, probe_hi = 1'b0, buz_req = 1'b0;
    logic [DP_W-1:0] dp_in = '0;
    logic [MAG_W-1:0] disp_mag;
    logic disp_neg, disp_ovr, show_ol, ovr_ann, lo_ann, hi_ann, buz_en;
    logic [DP_W-1:0] dp_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    phd_ctrl #(.MAG_W(MAG_W), .DP_W(DP_W)) dut (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .rd_mag(rd_mag), .rd_neg(rd_neg),
        .rd_ovr(rd_ovr), .freeze(freeze), .peak_en(peak_en), .probe_mode(probe_mode),
        .func_cnt(func_cnt), .probe_lo(probe_lo), .probe_hi(probe_hi), .buz_req(buz_req),
        .dp_in(dp_in), .disp_mag(disp_mag), .disp_neg(disp_neg), .disp_ovr(disp_ovr),
        .show_ol(show_ol), .ovr_ann(ovr_ann), .lo_ann(lo_ann), .hi_ann(hi_ann),
        .buz_en(buz_en), .dp_out(dp_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic fz, input logic pk);
        @(negedge clk);
        freeze  = fz;
        peak_en = pk;
        @(negedge clk);
    endtask

    task automatic conv(input int mag, input logic neg, input logic ovr);
        @(negedge clk);
        eoc = 1'b1; rd_mag = MAG_W'(mag); rd_neg = neg; rd_ovr = ovr;
        @(negedge clk);
        eoc = 1'b0;
    endtask

    task automatic chk_disp(input string req, input int mag, input int neg, input int ovr);
        check(req, int'(disp_mag), mag);
        check(req, int'(disp_neg), neg);
        check(req, int'(disp_ovr), ovr);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_disp("R1", 0, 0, 0);

        // R2 track load and no-strobe stability
        conv(9, 1'b1, 1'b0);
        chk_disp("R2", 9, 1, 0);
        @(negedge clk); rd_mag = 4'd3; rd_neg = 1'b0; rd_ovr = 1'b1;
        repeat (2) @(negedge clk);
        chk_disp("R2", 9, 1, 0);
        conv(2, 1'b0, 1'b0);
        chk_disp("R2", 2, 0, 0);

        // R3 freeze, alone and with peak-hold
        set_mode(1'b1, 1'b0);
        conv(14, 1'b1, 1'b0);
        chk_disp("R3", 2, 0, 0);
        set_mode(1'b1, 1'b1);
        conv(15, 1'b0, 1'b1);
        chk_disp("R3", 2, 0, 0);
        set_mode(1'b0, 1'b0);

        // R4 exhaustive peak sweep
        for (int s = 0; s < 16; s++) begin
            for (int n = 0; n < 16; n++) begin
                logic nn;
                nn = logic'(n % 2);
                set_mode(1'b0, 1'b0);
                conv(s, 1'b0, 1'b0);
                set_mode(1'b0, 1'b1);
                conv(n, nn, 1'b0);
                if (n > s) chk_disp("R4", n, int'(nn), 0);
                else       chk_disp("R4", s, 0, 0);
            end
        end
        // R4 held across many strobes
        set_mode(1'b0, 1'b0);
        conv(12, 1'b0, 1'b0);
        set_mode(1'b0, 1'b1);
        for (int k = 0; k < 12; k++) conv(k, 1'b1, 1'b0);
        chk_disp("R4", 12, 0, 0);

        // R5 over-range ordering in peak mode
        conv(15, 1'b0, 1'b0);
        conv(3, 1'b0, 1'b1);
        chk_disp("R5", 3, 0, 1);
        conv(9, 1'b1, 1'b1);
        chk_disp("R5", 3, 0, 1);
        conv(15, 1'b1, 1'b0);
        chk_disp("R5", 3, 0, 1);
        check("R8", int'(show_ol), 1);
        check("R8", int'(ovr_ann), 1);

        // R6 release of peak-hold
        set_mode(1'b0, 1'b0);
        conv(1, 1'b0, 1'b0);
        chk_disp("R6", 1, 0, 0);
        check("R8", int'(ovr_ann), 0);

        // R7 mode and strobe in the same cycle
        conv(10, 1'b0, 1'b0);
        @(negedge clk);
        peak_en = 1'b1; eoc = 1'b1; rd_mag = 4'd4; rd_neg = 1'b0; rd_ovr = 1'b0;
        @(negedge clk);
        eoc = 1'b0;
        chk_disp("R7", 4, 0, 0);
        conv(2, 1'b0, 1'b0);
        chk_disp("R7", 4, 0, 0);
        set_mode(1'b0, 1'b0);

        // R8..R11 status sweep (stored over-range is 0 here)
        dp_in = 3'b101;
        for (int c = 0; c < 32; c++) begin
            logic pm, fc, pl, ph, br;
            {pm, fc, pl, ph, br} = 5'(c);
            @(negedge clk);
            probe_mode = pm; func_cnt = fc; probe_lo = pl; probe_hi = ph; buz_req = br;
            #1;
            check("R8",  int'(show_ol), int'(pm));
            check("R9",  int'(lo_ann), int'(pm & pl));
            check("R9",  int'(hi_ann), int'(pm & ph));
            check("R10", int'(buz_en), int'(br | (pm & pl)));
            check("R11", int'(dp_out), (pm && !fc) ? 0 : 5);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule